// File: doc/BRIEF.md
# Identifier Acceptance Filter

This block takes the identifier of a frame just received from the bus and searches a table of message objects for one that should accept it. Each object carries a valid flag, a 29-bit identifier, a format flag (11-bit or 29-bit), a direction flag, a use-mask flag, and a 29-bit mask with two extra mask bits: one for the format bit and one for the direction bit. A mask bit of 1 means "this bit must agree". A mask bit of 0 means the bit can never block a match. When an object does not use its mask, every bit it compares must agree. An object in 11-bit format compares only the top eleven positions (28 down to 18) of the identifier field.

The frame handler pulses `start_i` for one cycle while the received identifier, IDE bit and remote flag are on the inputs. A fixed number of cycles later, `hit_o` and `hit_idx_o` give the result. If several objects match, the lowest-numbered one is reported. The result holds until the next strobe produces a new one. The object table is presented as flat vectors, and each field of object *k* sits at slice *k*.

Top module: `idf_filter`

## Requirements
- R1: An object whose valid bit is 0 never produces a hit, whatever its other fields hold.
- R2: With use-mask set, an identifier bit whose mask bit is 1 must equal the received bit. A bit whose mask bit is 0 never prevents a hit.
- R3: With use-mask set, the object's format flag is compared with the received IDE bit only when its mask-extended bit is 1.
- R4: With use-mask clear, every identifier bit in the object's format, the format flag against IDE, and the direction flag are all compared exactly.
- R5: An object with format flag 0 (11-bit) compares only identifier bits 28..18. Bits 17..0 never prevent a hit. An object with format flag 1 compares all 29 bits.
- R6: When direction is compared, a data frame (`rx_remote_i`=0) needs direction 0 (receive) and a remote frame (`rx_remote_i`=1) needs direction 1 (transmit). With use-mask set and mask-direction 0, direction is not compared.
- R7: If several objects hit, `hit_idx_o` is the lowest object number (0-based). With no hit, `hit_o`=0 and `hit_idx_o`=0.
- R8: With the default pipelined variant, the result of a strobe sampled at clock edge E appears after edge E+1 (two edges). The outputs keep their value at every edge that does not complete a search.
- R9: After reset, `hit_o`=0 and `hit_idx_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| obj_valid_i | input | NUM_OBJ | Valid flag per object |
| obj_id_i | input | NUM_OBJ*ID_W | Identifier per object |
| obj_ext_i | input | NUM_OBJ | Format flag per object (1 = 29-bit) |
| obj_dir_i | input | NUM_OBJ | Direction per object (1 = transmit) |
| obj_use_mask_i | input | NUM_OBJ | Use-mask flag per object |
| obj_mask_i | input | NUM_OBJ*ID_W | Identifier mask per object (1 = compare) |
| obj_mask_ext_i | input | NUM_OBJ | Mask bit for the format flag |
| obj_mask_dir_i | input | NUM_OBJ | Mask bit for the direction flag |
| rx_id_i | input | ID_W | Received identifier (11-bit ids in bits 28..18) |
| rx_ide_i | input | 1 | Received IDE bit |
| rx_remote_i | input | 1 | Received frame is a remote frame |
| start_i | input | 1 | One-cycle search strobe |
| hit_o | output | 1 | Some object accepted the frame |
| hit_idx_o | output | clog2(NUM_OBJ) | Lowest accepting object number |

## Verification
A wrong match term in one object shows up at the ports as a missed hit or as a hit on the wrong number. This appears two edges after the strobe, but only when no lower-numbered object also hits. For this reason the bench runs the priority cases with a single candidate as well as with several. A wrong pipeline state, such as a lost pending flag or a register updated without a strobe, shows up either as a result arriving one edge early or late, or as an output that drifts between strobes. A reference model compares the outputs on every cycle, so such a fault is caught at the first cycle where it differs.

// File: rtl/idf_pkg.sv
package idf_pkg;
   localparam int unsigned IDF_ID_W  = 29;
   localparam int unsigned IDF_STD_W = 11;

   typedef enum logic {
      IDF_PIPE_COMB = 1'b0,
      IDF_PIPE_REG  = 1'b1
   } idf_pipe_e;

   function automatic int unsigned idf_latency(idf_pipe_e p);
      return (p == IDF_PIPE_REG) ? 2 : 1;
   endfunction
endpackage

// File: rtl/idf_entry_match.sv
module idf_entry_match #(
   parameter int unsigned ID_W  = idf_pkg::IDF_ID_W,
   parameter int unsigned STD_W = idf_pkg::IDF_STD_W
) (
   input  logic            valid_i,
   input  logic [ID_W-1:0] id_i,
   input  logic            ext_i,
   input  logic            dir_i,
   input  logic            use_mask_i,
   input  logic [ID_W-1:0] mask_i,
   input  logic            mask_ext_i,
   input  logic            mask_dir_i,
   input  logic [ID_W-1:0] rx_id_i,
   input  logic            rx_ide_i,
   input  logic            rx_remote_i,
   output logic            match_o
);
   localparam int unsigned LOW_W = ID_W - STD_W;
   localparam logic [ID_W-1:0] STD_KEEP = {{STD_W{1'b1}}, {LOW_W{1'b0}}};

   logic [ID_W-1:0] fmt_keep;
   logic [ID_W-1:0] id_care;
   logic            ide_care;
   logic            dir_care;
   logic            id_ok;
   logic            ide_ok;
   logic            dir_ok;

   always_comb begin
      fmt_keep = ext_i ? {ID_W{1'b1}} : STD_KEEP;
      id_care  = use_mask_i ? mask_i : {ID_W{1'b1}};
      ide_care = use_mask_i ? mask_ext_i : 1'b1;
      dir_care = use_mask_i ? mask_dir_i : 1'b1;
      id_ok    = (((id_i ^ rx_id_i) & id_care & fmt_keep) == '0);
      ide_ok   = !ide_care || (ext_i == rx_ide_i);
      dir_ok   = !dir_care || (dir_i == rx_remote_i);
      match_o  = valid_i && id_ok && ide_ok && dir_ok;
   end
endmodule

// File: rtl/idf_first_hit.sv
module idf_first_hit #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (vec_i[k]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/idf_filter.sv
module idf_filter #(
   parameter int unsigned       NUM_OBJ = 32,
   parameter int unsigned       ID_W    = idf_pkg::IDF_ID_W,
   parameter int unsigned       STD_W   = idf_pkg::IDF_STD_W,
   parameter idf_pkg::idf_pipe_e PIPE   = idf_pkg::IDF_PIPE_REG
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_OBJ-1:0]         obj_valid_i,
   input  logic [NUM_OBJ*ID_W-1:0]    obj_id_i,
   input  logic [NUM_OBJ-1:0]         obj_ext_i,
   input  logic [NUM_OBJ-1:0]         obj_dir_i,
   input  logic [NUM_OBJ-1:0]         obj_use_mask_i,
   input  logic [NUM_OBJ*ID_W-1:0]    obj_mask_i,
   input  logic [NUM_OBJ-1:0]         obj_mask_ext_i,
   input  logic [NUM_OBJ-1:0]         obj_mask_dir_i,
   input  logic [ID_W-1:0]            rx_id_i,
   input  logic                       rx_ide_i,
   input  logic                       rx_remote_i,
   input  logic                       start_i,
   output logic                       hit_o,
   output logic [$clog2(NUM_OBJ)-1:0] hit_idx_o
);
   localparam int unsigned IDX_W = $clog2(NUM_OBJ);
   localparam logic [NUM_OBJ-1:0] ONE_N = {{(NUM_OBJ-1){1'b0}}, 1'b1};

   initial begin
      assert (NUM_OBJ >= 2) else $error("idf_filter: NUM_OBJ must be at least 2");
      assert (STD_W > 0 && STD_W < ID_W) else $error("idf_filter: STD_W must lie inside ID_W");
      assert (idf_pkg::idf_latency(PIPE) >= 1) else $error("idf_filter: bad pipeline variant");
   end

   logic [NUM_OBJ-1:0] match_now;
   logic [NUM_OBJ-1:0] enc_vec;
   logic               enc_load;
   logic               enc_any;
   logic [IDX_W-1:0]   enc_idx;

   // one comparator per object
   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
      idf_entry_match #(.ID_W(ID_W), .STD_W(STD_W)) u_cmp (
         .valid_i     (obj_valid_i[g]),
         .id_i        (obj_id_i[g*ID_W +: ID_W]),
         .ext_i       (obj_ext_i[g]),
         .dir_i       (obj_dir_i[g]),
         .use_mask_i  (obj_use_mask_i[g]),
         .mask_i      (obj_mask_i[g*ID_W +: ID_W]),
         .mask_ext_i  (obj_mask_ext_i[g]),
         .mask_dir_i  (obj_mask_dir_i[g]),
         .rx_id_i     (rx_id_i),
         .rx_ide_i    (rx_ide_i),
         .rx_remote_i (rx_remote_i),
         .match_o     (match_now[g])
      );

      // R1: an invalid object never contributes a match
      assert_invalid_never_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
         !obj_valid_i[g] |-> !match_now[g]);

      // R6: a compared direction that disagrees blocks the match
      assert_dir_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ((obj_dir_i[g] != rx_remote_i) && (!obj_use_mask_i[g] || obj_mask_dir_i[g]))
         |-> !match_now[g]);
   end

   // pipeline variant selection
   if (PIPE == idf_pkg::IDF_PIPE_REG) begin : g_reg
      logic [NUM_OBJ-1:0] match_q;
      logic               pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q <= '0;
            pend_q  <= 1'b0;
         end else begin
            pend_q <= start_i;
            if (start_i) match_q <= match_now;
         end
      end
      assign enc_vec  = match_q;
      assign enc_load = pend_q;
   end else begin : g_comb
      assign enc_vec  = match_now;
      assign enc_load = start_i;
   end

   idf_first_hit #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_first (
      .vec_i (enc_vec),
      .any_o (enc_any),
      .idx_o (enc_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o     <= 1'b0;
         hit_idx_o <= '0;
      end else if (enc_load) begin
         hit_o     <= enc_any;
         hit_idx_o <= enc_idx;
      end
   end

   logic [NUM_OBJ-1:0] below_mask;
   assign below_mask = (ONE_N << enc_idx) - ONE_N;

   // R7: the chosen object really matched, and no lower object did
   assert_pick_is_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_load && enc_any) |-> enc_vec[enc_idx]);
   assert_pick_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_load && enc_any) |-> ((enc_vec & below_mask) == '0));
   assert_nohit_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (hit_idx_o == '0));
   assert_empty_gives_nohit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_load && (enc_vec == '0)) |=> !hit_o);

   // R8: outputs hold between completed searches
   assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_load |=> ($stable(hit_o) && $stable(hit_idx_o)));
endmodule

// File: tb/tb_idf_filter.sv
`timescale 1ns/1ps
module tb_idf_filter;
   localparam int N  = 32;
   localparam int W  = 29;
   localparam int IW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          e_val [N];
   logic [W-1:0]  e_id  [N];
   logic          e_ext [N];
   logic          e_dir [N];
   logic          e_um  [N];
   logic [W-1:0]  e_msk [N];
   logic          e_mx  [N];
   logic          e_md  [N];

   logic [N-1:0]   p_val, p_ext, p_dir, p_um, p_mx, p_md;
   logic [N*W-1:0] p_id, p_msk;
   logic [W-1:0]   rx_id = '0;
   logic           rx_ide = 1'b0, rx_rem = 1'b0, start = 1'b0;
   logic           hit;
   logic [IW-1:0]  idx;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         p_val[i] = e_val[i]; p_ext[i] = e_ext[i]; p_dir[i] = e_dir[i];
         p_um[i]  = e_um[i];  p_mx[i]  = e_mx[i];  p_md[i]  = e_md[i];
         p_id[i*W +: W]  = e_id[i];
         p_msk[i*W +: W] = e_msk[i];
      end
   end

   idf_filter dut (
      .clk(clk), .rst_n(rst_n),
      .obj_valid_i(p_val), .obj_id_i(p_id), .obj_ext_i(p_ext), .obj_dir_i(p_dir),
      .obj_use_mask_i(p_um), .obj_mask_i(p_msk), .obj_mask_ext_i(p_mx),
      .obj_mask_dir_i(p_md), .rx_id_i(rx_id), .rx_ide_i(rx_ide),
      .rx_remote_i(rx_rem), .start_i(start), .hit_o(hit), .hit_idx_o(idx)
   );

   int tests = 0;
   int fails = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference: bit-by-bit walk, first match wins
   function automatic int ref_pick();
      for (int i = 0; i < N; i++) begin
         bit ok;
         if (!e_val[i]) continue;
         ok = 1;
         for (int b = 0; b < W; b++) begin
            if (!e_ext[i] && b < 18) continue;
            if ((!e_um[i] || e_msk[i][b]) && (e_id[i][b] != rx_id[b])) ok = 0;
         end
         if ((!e_um[i] || e_mx[i]) && (e_ext[i] != rx_ide)) ok = 0;
         if ((!e_um[i] || e_md[i]) && (e_dir[i] != rx_rem)) ok = 0;
         if (ok) return i;
      end
      return -1;
   endfunction

   int q_res[$];
   int q_due[$];
   int cyc = 0;
   int m_hit = 0;
   int m_idx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_res.delete(); q_due.delete(); m_hit = 0; m_idx = 0;
      end else begin
         if (q_due.size() > 0 && q_due[0] == cyc) begin
            int r;
            r = q_res.pop_front();
            void'(q_due.pop_front());
            m_hit = (r >= 0) ? 1 : 0;
            m_idx = (r >= 0) ? r : 0;
         end
         if (start) begin
            q_res.push_back(ref_pick());
            q_due.push_back(cyc + 1);
         end
      end
      cyc++;
   end

   // per-cycle comparison against the model (R8 timing and hold)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 model hit", int'(hit), m_hit);
         chk("R8 model idx", int'(idx), m_idx);
      end
   end

   task automatic clear_all();
      for (int i = 0; i < N; i++) begin
         e_val[i] = 0; e_id[i] = '0; e_ext[i] = 0; e_dir[i] = 0;
         e_um[i] = 0; e_msk[i] = '0; e_mx[i] = 0; e_md[i] = 0;
      end
   endtask

   task automatic std_obj(input int k, input logic [10:0] sid);
      e_val[k] = 1; e_id[k] = {sid, 18'h0}; e_ext[k] = 0; e_dir[k] = 0; e_um[k] = 0;
   endtask

   task automatic run_case(input string tag, input int ehit, input int eidx);
      int ph, pi;
      ph = int'(hit); pi = int'(idx);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk({tag, " R8 not early hit"}, int'(hit), ph);
      chk({tag, " R8 not early idx"}, int'(idx), pi);
      @(negedge clk);
      chk({tag, " hit"}, int'(hit), ehit);
      chk({tag, " idx"}, int'(idx), eidx);
   endtask

   initial begin
      clear_all();
      repeat (3) @(negedge clk);
      chk("R9 reset hit", int'(hit), 0);
      chk("R9 reset idx", int'(idx), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R9 after release hit", int'(hit), 0);

      rx_id = 29'h0ABCDE01;
      run_case("R1 empty table", 0, 0);

      std_obj(5, 11'h123);
      rx_id = {11'h123, 18'h2AAAA}; rx_ide = 0; rx_rem = 0;
      run_case("R5 std low bits ignored", 1, 5);
      e_val[5] = 0;
      run_case("R1 invalid object", 0, 0);
      e_val[5] = 1;
      rx_id = {11'h122, 18'h2AAAA};
      run_case("R5 std bit18 compared", 0, 0);

      e_val[9] = 1; e_id[9] = 29'h1ABCDEF0; e_ext[9] = 1; e_dir[9] = 0; e_um[9] = 0;
      rx_id = 29'h1ABCDEF0; rx_ide = 1;
      run_case("R4 exact extended", 1, 9);
      rx_id = 29'h1ABCDEF1;
      run_case("R4 exact one bit off", 0, 0);

      e_um[9] = 1; e_msk[9] = ~29'hF; e_mx[9] = 1; e_md[9] = 1;
      run_case("R2 masked bit ignored", 1, 9);
      rx_id = 29'h1ABCDEE0;
      run_case("R2 care bit compared", 0, 0);

      rx_id = 29'h1ABCDEF0; rx_ide = 0;
      run_case("R3 ide compared", 0, 0);
      e_mx[9] = 0;
      run_case("R3 ide masked", 1, 9);

      rx_ide = 1; e_mx[9] = 1; rx_rem = 1;
      run_case("R6 remote vs receive obj", 0, 0);
      e_dir[9] = 1;
      run_case("R6 remote vs transmit obj", 1, 9);
      rx_rem = 0; e_md[9] = 0;
      run_case("R6 direction masked", 1, 9);

      clear_all();
      std_obj(3, 11'h7FF); std_obj(7, 11'h7FF); std_obj(20, 11'h7FF);
      rx_id = {11'h7FF, 18'h0}; rx_ide = 0; rx_rem = 0;
      run_case("R7 lowest of three", 1, 3);
      e_val[3] = 0;
      run_case("R7 next lowest", 1, 7);
      clear_all();
      std_obj(31, 11'h7FF);
      run_case("R7 top object", 1, 31);
      std_obj(0, 11'h7FF);
      run_case("R7 object zero", 1, 0);

      rx_id = '0; e_val[0] = 0;
      repeat (5) @(negedge clk);
      chk("R8 held hit", int'(hit), 1);
      chk("R8 held idx", int'(idx), 0);
      run_case("R7 nohit idx zero", 0, 0);

      // back-to-back strobes
      rx_id = {11'h7FF, 18'h0};
      @(negedge clk); start = 1;
      @(negedge clk); rx_id = '0;
      @(negedge clk); start = 0;
      chk("R8 first of pair", int'(idx), 31);
      @(negedge clk);
      chk("R8 second of pair", int'(hit), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule